// File: doc/BRIEF.md
# Erase Busy Timer and Status Byte

This block keeps the embedded-operation status of a NOR flash command engine. When the command sequencer accepts an erase, it sends a single-cycle start pulse with a flag that selects sector or chip erase. The block then counts down for an interval that is set per erase type. During that interval it reports busy. The status byte it shows is cleared when the erase is accepted. Bit 6 of the byte flips after every status read taken while busy, so polling software sees a toggling bit. When the interval runs out, bit 7 is inverted and the block gives a one-cycle done pulse. With the done pulse it says whether the sequencer should go back to the post-unlock command cycle, because bypass was active, or to plain read mode.

A completed program cycle also writes the status byte: bit 7 takes the inverse of data bit 7. The array contents are not handled here. Each duration is set as a number of milliseconds times a clock-to-millisecond scaling parameter. A small bench can therefore shrink the seconds-long erase intervals to a few thousand cycles.

Top module: `flash_erase_status`

## Requirements
- R1: After reset, status_o is 00h, and busy_o, done_o and to_bypass_o are 0.
- R2: A start_i pulse while busy_o is 0 clears status_o to 00h and raises busy_o from the next cycle.
- R3: busy_o stays high for exactly SECTOR_MS*CYC_PER_MS cycles when chip_i was 0 at the accepted start, and for CHIP_MS*CYC_PER_MS cycles when chip_i was 1.
- R4: In the cycle after busy_o falls, done_o is high for exactly one cycle, and status_o bit 7 is the inverse of its value in the last busy cycle.
- R5: A stat_rd_i strobe while busy_o is 1 leaves status_o unchanged in that cycle and inverts status_o bit 6 from the next cycle on.
- R6: A stat_rd_i strobe while busy_o is 0 leaves status_o unchanged.
- R7: A start_i pulse while busy_o is 1 is ignored. The count is not reloaded, so the end time is unchanged, and status_o is not cleared.
- R8: to_bypass_o is high only together with done_o, and then it equals the value bypass_i had in the last busy cycle. 1 means the sequencer returns to the post-unlock command cycle, and 0 means it returns to read mode.
- R9: A prog_i pulse while busy_o is 0 sets status_o bit 7 to the inverse of prog_d7_i and keeps bits 6:0. While busy_o is 1, prog_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Erase start pulse from the command sequencer |
| chip_i | input | 1 | Erase type with start_i: 1 chip, 0 sector |
| prog_i | input | 1 | Program cycle completed pulse |
| prog_d7_i | input | 1 | Bit 7 of the programmed data, valid with prog_i |
| stat_rd_i | input | 1 | Status read strobe |
| bypass_i | input | 1 | Bypass mode active level from the sequencer |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Erase interval running |
| done_o | output | 1 | One-cycle pulse at the end of an erase |
| to_bypass_o | output | 1 | With done_o: return to the command cycle (1) or to read mode (0) |

## Verification
The bench builds the block with CYC_PER_MS at 2 and keeps the millisecond counts at their defaults. The sector interval then becomes 1000 cycles and the chip interval 10000 cycles. At these lengths both erase types can be run through to completion, with the exact last busy cycle and the done cycle sampled for each. A second start can also be placed inside a running sector erase, so the bench can confirm that the end time does not move.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic {
      ER_SECTOR = 1'b0,
      ER_CHIP   = 1'b1
   } erase_kind_e;

   localparam int unsigned STAT_W      = 8;
   localparam int unsigned POLL_BIT    = 6;
   localparam int unsigned DONE_BIT    = 7;
endpackage

// File: rtl/fes_timer.sv
module fes_timer
   import fes_pkg::*;
#(
   parameter int unsigned CHIP_CYC   = 10000,
   parameter int unsigned SECTOR_CYC = 1000,
   localparam int unsigned MAX_CYC   = (CHIP_CYC > SECTOR_CYC) ? CHIP_CYC : SECTOR_CYC,
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  erase_kind_e kind,
   input  logic        bypass,
   output logic        busy,
   output logic        expire,
   output logic        done,
   output logic        to_bypass
);
   localparam logic [CNT_W-1:0] CHIP_LD   = CNT_W'(CHIP_CYC - 1);
   localparam logic [CNT_W-1:0] SECTOR_LD = CNT_W'(SECTOR_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic             accept;

   generate
      if (CHIP_CYC == SECTOR_CYC) begin : g_one_len
         assign load_val = CHIP_LD;
      end else begin : g_two_len
         assign load_val = (kind == ER_CHIP) ? CHIP_LD : SECTOR_LD;
      end
   endgenerate

   assign accept = start && !busy;
   assign expire = busy && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         to_bypass <= 1'b0;
      end else begin
         done      <= expire;
         to_bypass <= expire && bypass;
         if (accept) begin
            cnt_q <= load_val;
            busy  <= 1'b1;
         end else if (expire) begin
            busy  <= 1'b0;
         end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/fes_status.sv
module fes_status
   import fes_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              poll_tgl,
   input  logic              flip_done,
   input  logic              prog_set,
   input  logic              prog_d7,
   output logic [STAT_W-1:0] status
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
      end else if (clr) begin
         status <= '0;
      end else begin
         if (prog_set)  status[DONE_BIT] <= ~prog_d7;
         if (flip_done) status[DONE_BIT] <= ~status[DONE_BIT];
         if (poll_tgl)  status[POLL_BIT] <= ~status[POLL_BIT];
      end
   end
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
   import fes_pkg::*;
#(
   parameter int unsigned CHIP_MS    = 5000,
   parameter int unsigned SECTOR_MS  = 500,
   parameter int unsigned CYC_PER_MS = 125000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       chip_i,
   input  logic       prog_i,
   input  logic       prog_d7_i,
   input  logic       stat_rd_i,
   input  logic       bypass_i,
   output logic [7:0] status_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       to_bypass_o
);
   localparam int unsigned CHIP_CYC   = CHIP_MS * CYC_PER_MS;
   localparam int unsigned SECTOR_CYC = SECTOR_MS * CYC_PER_MS;

   generate
      if (CHIP_CYC < 1 || SECTOR_CYC < 1) begin : g_bad_len
         $error("erase lengths must be at least one cycle");
      end
      if (STAT_W != 8) begin : g_bad_width
         $error("status byte must be eight bits");
      end
   endgenerate

   logic        busy;
   logic        expire;
   erase_kind_e kind;

   assign kind = chip_i ? ER_CHIP : ER_SECTOR;

   fes_timer #(
      .CHIP_CYC   (CHIP_CYC),
      .SECTOR_CYC (SECTOR_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .kind      (kind),
      .bypass    (bypass_i),
      .busy      (busy),
      .expire    (expire),
      .done      (done_o),
      .to_bypass (to_bypass_o)
   );

   fes_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_i && !busy),
      .poll_tgl  (stat_rd_i && busy),
      .flip_done (expire),
      .prog_set  (prog_i && !busy),
      .prog_d7   (prog_d7_i),
      .status    (status_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
   parameter int unsigned CHIP_MS    = 5000,
   parameter int unsigned SECTOR_MS  = 500,
   parameter int unsigned CYC_PER_MS = 125000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       chip_i,
   input logic       prog_i,
   input logic       prog_d7_i,
   input logic       stat_rd_i,
   input logic       bypass_i,
   input logic [7:0] status_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       to_bypass_o
);
   logic [31:0] blen_q;
   logic [31:0] want_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blen_q <= '0;
         want_q <= '0;
      end else if (start_i && !busy_o) begin
         blen_q <= 32'd1;
         want_q <= chip_i ? CHIP_MS * CYC_PER_MS : SECTOR_MS * CYC_PER_MS;
      end else if (busy_o) begin
         blen_q <= blen_q + 32'd1;
      end
   end

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && status_o == 8'h00);

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> blen_q == want_q + 32'd1);

   // R4
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o && status_o[7] != $past(status_o[7]));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i && busy_o |=> status_o[6] != $past(status_o[6]));

   // R6
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i && !busy_o && !start_i && !prog_i |=> $stable(status_o));

   // R8
   bypass_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_bypass_o |-> done_o);

   // R9
   prog_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_i && !busy_o && !start_i |=>
         status_o[7] == !$past(prog_d7_i) && status_o[6:0] == $past(status_o[6:0]));
endmodule

bind flash_erase_status fes_chk #(
   .CHIP_MS    (CHIP_MS),
   .SECTOR_MS  (SECTOR_MS),
   .CYC_PER_MS (CYC_PER_MS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .chip_i      (chip_i),
   .prog_i      (prog_i),
   .prog_d7_i   (prog_d7_i),
   .stat_rd_i   (stat_rd_i),
   .bypass_i    (bypass_i),
   .status_o    (status_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .to_bypass_o (to_bypass_o)
);

// File: tb/flash_erase_status_tb.sv
module flash_erase_status_tb;
   localparam int unsigned CHIP_MS    = 5000;
   localparam int unsigned SECTOR_MS  = 500;
   localparam int unsigned CYC_PER_MS = 2;
   localparam int          LEN_SEC    = SECTOR_MS * CYC_PER_MS;
   localparam int          LEN_CHIP   = CHIP_MS * CYC_PER_MS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       chip_i = 1'b0;
   logic       prog_i = 1'b0;
   logic       prog_d7_i = 1'b0;
   logic       stat_rd_i = 1'b0;
   logic       bypass_i = 1'b0;
   logic [7:0] status_o;
   logic       busy_o;
   logic       done_o;
   logic       to_bypass_o;

   int total = 0;
   int bad   = 0;
   int el    = 0;

   always #4 clk = ~clk;

   flash_erase_status #(
      .CHIP_MS    (CHIP_MS),
      .SECTOR_MS  (SECTOR_MS),
      .CYC_PER_MS (CYC_PER_MS)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .chip_i      (chip_i),
      .prog_i      (prog_i),
      .prog_d7_i   (prog_d7_i),
      .stat_rd_i   (stat_rd_i),
      .bypass_i    (bypass_i),
      .status_o    (status_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .to_bypass_o (to_bypass_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         el++;
      end
   endtask

   task automatic launch(logic chip);
      start_i = 1'b1;
      chip_i  = chip;
      el      = 0;
      step(1);
      start_i = 1'b0;
   endtask

   task automatic poll(string req);
      logic [7:0] seen;
      seen      = status_o;
      stat_rd_i = 1'b1;
      step(1);
      stat_rd_i = 1'b0;
      check(req, status_o, seen ^ 8'h40);
   endtask

   task automatic t_reset();
      check("R1 status", status_o, 8'h00);
      check("R1 busy", busy_o, 0);
      check("R1 done", done_o, 0);
      check("R1 to_bypass", to_bypass_o, 0);
   endtask

   task automatic t_sector();
      launch(1'b0);
      check("R2 busy after start", busy_o, 1);
      check("R2 status cleared", status_o, 8'h00);
      step(10);
      poll("R5 first poll");
      poll("R5 second poll");
      step(LEN_SEC - el);
      check("R3 sector still busy at last cycle", busy_o, 1);
      check("R3 no done before end", done_o, 0);
      step(1);
      check("R3 sector busy dropped", busy_o, 0);
      check("R4 done pulse", done_o, 1);
      check("R4 bit7 flipped", status_o, 8'h80);
      check("R8 to read mode", to_bypass_o, 0);
      step(1);
      check("R4 done single cycle", done_o, 0);
   endtask

   task automatic t_idle_read();
      stat_rd_i = 1'b1;
      step(1);
      stat_rd_i = 1'b0;
      check("R6 idle read no change", status_o, 8'h80);
      step(1);
      check("R6 idle read later", status_o, 8'h80);
   endtask

   task automatic t_prog();
      prog_i = 1'b1; prog_d7_i = 1'b1;
      step(1);
      prog_i = 1'b0;
      check("R9 prog d7=1", status_o, 8'h00);
      prog_i = 1'b1; prog_d7_i = 1'b0;
      step(1);
      prog_i = 1'b0;
      check("R9 prog d7=0", status_o, 8'h80);
   endtask

   task automatic t_chip_bypass();
      bypass_i = 1'b1;
      launch(1'b1);
      check("R2 chip status cleared", status_o, 8'h00);
      poll("R5 chip poll");
      prog_i = 1'b1; prog_d7_i = 1'b0;
      step(1);
      prog_i = 1'b0;
      check("R9 prog ignored while busy", status_o, 8'h40);
      step(LEN_CHIP - el);
      check("R3 chip still busy at last cycle", busy_o, 1);
      step(1);
      check("R3 chip busy dropped", busy_o, 0);
      check("R4 chip done", done_o, 1);
      check("R4 chip bit7 flipped", status_o, 8'hC0);
      check("R8 to bypass", to_bypass_o, 1);
      step(1);
      check("R8 to_bypass clears with done", to_bypass_o, 0);
      bypass_i = 1'b0;
   endtask

   task automatic t_ignore_start();
      launch(1'b0);
      step(50);
      poll("R5 before ignored start");
      start_i = 1'b1; chip_i = 1'b1;
      step(1);
      start_i = 1'b0;
      check("R7 status not cleared", status_o, 8'h40);
      step(LEN_SEC - el);
      check("R7 busy at original last cycle", busy_o, 1);
      step(1);
      check("R7 end not moved", busy_o, 0);
      check("R7 done at original time", done_o, 1);
      check("R4 status at end", status_o, 8'hC0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_sector();
      t_idle_read();
      t_prog();
      t_chip_bypass();
      step(2);
      t_ignore_start();
      step(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule